// File: doc/BRIEF.md
# Audio Master-Clock Monitor with Error-Driven Mute

This block watches the high-frequency audio master clock from the system clock domain. It brings the master clock in through a flop synchronizer and counts its rising edges over back-to-back windows of a fixed number of system cycles (32 by default). At the end of each window it publishes the count as a frequency measurement and pulses a strobe. The count is compared against programmable lower and upper limits. A count outside the limits raises a clock-range error. The comparison is skipped for the first window after reset, because that window starts at an arbitrary phase.

The clock-range error is combined with four other sources: serial protocol error, data underrun, data overrun and an external mute request. Each source latches into a sticky flag, and software clears a flag by writing a one to its bit. A per-source mute select drives a mute output whose active level is chosen by a polarity input. The mute responds in the same cycle that a selected source fires. A separate per-source interrupt select drives an interrupt line.

Top module: `clkmon_mute`

## Requirements
- R1: Every WIN system cycles (WIN=32) `meas_stb` is high for exactly one cycle. In that cycle `meas_count` holds the number of master-clock rising edges seen in the window just ended. The master clock must be slower than half the system clock.
- R2: At the end of every window except the first, a count below `lim_lo` or above `lim_hi` sets flag bit 3 (clock range) one cycle after `meas_stb`. A count inside the limits sets nothing.
- R3: The range comparison of the first window after reset is ignored. Bit 3 stays clear even if that count is out of limits.
- R4: `err_flags` bit order is 0 protocol, 1 underrun, 2 overrun, 3 clock range, 4 external mute. A source pulse sets its bit at the next clock edge, and the bit stays set until a one is written to the same bit of `clr_w1c`. If a set and a clear of the same bit land in the same cycle, the set wins.
- R5: `mute_out` is at its active level when any flag, or any source firing in the current cycle, has its `mute_en` bit set. The active level is high when `mute_pol`=1 and low when `mute_pol`=0. The response is combinational and takes no clock edge.
- R6: A source whose `mute_en` bit is 0 does not affect `mute_out`, either while it fires or after its flag is set.
- R7: `irq` is high exactly when some flag is set whose `irq_en` bit is 1.
- R8: During reset, `err_flags`=0, `meas_count`=0, `meas_stb`=0, `irq`=0, and `mute_out` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mclk_in | input | 1 | Master clock, asynchronous to clk_sys |
| lim_lo | input | CW (6) | Lowest acceptable window count |
| lim_hi | input | CW (6) | Highest acceptable window count |
| src_proto_err | input | 1 | Serial protocol error pulse |
| src_underrun | input | 1 | Data underrun pulse |
| src_overrun | input | 1 | Data overrun pulse |
| src_ext_mute | input | 1 | External mute request |
| mute_en | input | 5 | Per-source mute select |
| irq_en | input | 5 | Per-source interrupt select |
| mute_pol | input | 1 | Mute active level (1 = high) |
| clr_w1c | input | 5 | Write-one-to-clear for the flags |
| meas_count | output | CW (6) | Latest window edge count |
| meas_stb | output | 1 | One-cycle pulse when meas_count updates |
| err_flags | output | 5 | Sticky error flags |
| mute_out | output | 1 | Mute, polarity per mute_pol |
| irq | output | 1 | Interrupt |

## Verification
The bound checker checks several properties on every cycle. The strobe is spaced by exactly one window. A range flag rises only right after a strobe and never after the first window. An uncleared flag never drops. Any enabled flag holds the mute at its active level.

Only the bench scenarios can show the following. The counts are correct for master clocks of three different periods. The limit checks work below and above the range. The combinational mute responds within the same cycle. The polarity and source selection work, as does the interrupt gating.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  localparam int NSRC      = 5;
  localparam int IDX_PROTO = 0;
  localparam int IDX_UNDER = 1;
  localparam int IDX_OVER  = 2;
  localparam int IDX_RANGE = 3;
  localparam int IDX_EXT   = 4;
  typedef logic [NSRC-1:0] srcvec_t;
endpackage

// File: rtl/mclk_edge_sync.sv
`timescale 1ns/1ps
// Brings an asynchronous clock into the system domain and emits one pulse per rising edge.
module mclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/mclk_window_meter.sv
`timescale 1ns/1ps
// Counts edge pulses over fixed windows, publishes the count and checks it against limits.
module mclk_window_meter #(
  parameter int WIN = 32,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  output logic [CW-1:0] meas_o,
  output logic          stb_o,
  output logic          range_err_o
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WIN - 1);

  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [CW-1:0] acc_q, acc_d, acc_sum;
  logic [CW-1:0] meas_q, meas_d;
  logic          stb_q, stb_d;
  logic          armed_q, armed_d;
  logic          rerr_q, rerr_d;
  logic          wend;

  always_comb begin
    wend    = (wcnt_q == WLAST);
    acc_sum = acc_q + CW'(rise_i);
    wcnt_d  = wend ? '0 : wcnt_q + 1'b1;
    acc_d   = wend ? '0 : acc_sum;
    meas_d  = wend ? acc_sum : meas_q;
    stb_d   = wend;
    armed_d = armed_q | wend;
    rerr_d  = wend & armed_q & ((acc_sum < lim_lo) | (acc_sum > lim_hi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      acc_q   <= '0;
      meas_q  <= '0;
      stb_q   <= 1'b0;
      armed_q <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_d;
      acc_q   <= acc_d;
      stb_q   <= stb_d;
      armed_q <= armed_d;
      rerr_q  <= rerr_d;
      if (wend) meas_q <= meas_d;
    end
  end

  assign meas_o      = meas_q;
  assign stb_o       = stb_q;
  assign range_err_o = rerr_q;
endmodule

// File: rtl/err_mute_matrix.sv
`timescale 1ns/1ps
// Sticky error flags with write-one-to-clear, per-source mute and interrupt selection.
module err_mute_matrix
  import clkmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcvec_t set_i,
  input  srcvec_t clr_i,
  input  srcvec_t mute_sel,
  input  srcvec_t irq_sel,
  input  logic    pol_i,
  output srcvec_t flags_o,
  output logic    mute_o,
  output logic    irq_o
);
  srcvec_t flags_q, flags_d;
  logic    mute_req;

  always_comb begin
    flags_d  = (flags_q & ~clr_i) | set_i;
    mute_req = |((flags_q | set_i) & mute_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign mute_o  = pol_i ? mute_req : ~mute_req;
  assign irq_o   = |(flags_q & irq_sel);
endmodule

// File: rtl/clkmon_mute.sv
`timescale 1ns/1ps
module clkmon_mute
  import clkmon_pkg::*;
#(
  parameter int WIN         = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = $clog2(WIN + 1)
) (
  input  logic          clk_sys,
  input  logic          rst_n,
  input  logic          mclk_in,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  input  logic          src_proto_err,
  input  logic          src_underrun,
  input  logic          src_overrun,
  input  logic          src_ext_mute,
  input  logic [4:0]    mute_en,
  input  logic [4:0]    irq_en,
  input  logic          mute_pol,
  input  logic [4:0]    clr_w1c,
  output logic [CW-1:0] meas_count,
  output logic          meas_stb,
  output logic [4:0]    err_flags,
  output logic          mute_out,
  output logic          irq
);
  logic    mclk_rise;
  logic    range_err;
  srcvec_t set_vec;

  mclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_sys), .rst_n(rst_n), .async_in(mclk_in), .rise_o(mclk_rise)
  );

  mclk_window_meter #(.WIN(WIN), .CW(CW)) u_meter (
    .clk(clk_sys), .rst_n(rst_n), .rise_i(mclk_rise),
    .lim_lo(lim_lo), .lim_hi(lim_hi),
    .meas_o(meas_count), .stb_o(meas_stb), .range_err_o(range_err)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[IDX_PROTO] = src_proto_err;
    set_vec[IDX_UNDER] = src_underrun;
    set_vec[IDX_OVER]  = src_overrun;
    set_vec[IDX_RANGE] = range_err;
    set_vec[IDX_EXT]   = src_ext_mute;
  end

  err_mute_matrix u_matrix (
    .clk(clk_sys), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_w1c),
    .mute_sel(mute_en), .irq_sel(irq_en), .pol_i(mute_pol),
    .flags_o(err_flags), .mute_o(mute_out), .irq_o(irq)
  );
endmodule

// File: rtl/clkmon_mute_chk.sv
`timescale 1ns/1ps
module clkmon_mute_chk #(
  parameter int WIN = 32
) (
  input logic       clk_sys,
  input logic       rst_n,
  input logic       meas_stb,
  input logic [4:0] err_flags,
  input logic [4:0] clr_w1c,
  input logic [4:0] mute_en,
  input logic       mute_pol,
  input logic       mute_out
);
  localparam int GW = $clog2(WIN + 2);
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (meas_stb) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q != GW'(WIN + 1)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (meas_stb && seen_q) |-> (gap_q == GW'(WIN))); // R1

  AST_RANGE_AFTER_STB: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(err_flags[3]) |-> $past(meas_stb)); // R2

  AST_FIRST_WINDOW_SKIP: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (meas_stb && !seen_q) |=> !err_flags[3]); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk_sys) disable iff (!rst_n)
    1'b1 |=> ((err_flags & $past(err_flags & ~clr_w1c)) == $past(err_flags & ~clr_w1c))); // R4

  AST_MUTE_ACTIVE: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (|(err_flags & mute_en)) |-> (mute_out == mute_pol)); // R5
endmodule

bind clkmon_mute clkmon_mute_chk #(.WIN(WIN)) u_chk (
  .clk_sys(clk_sys), .rst_n(rst_n), .meas_stb(meas_stb), .err_flags(err_flags),
  .clr_w1c(clr_w1c), .mute_en(mute_en), .mute_pol(mute_pol), .mute_out(mute_out)
);

// File: tb/test_clkmon_mute.sv
`timescale 1ns/1ps
module test_clkmon_mute;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic mclk;
  int   mclk_half = 40;
  logic [CW-1:0] lim_lo, lim_hi;
  logic err_proto, err_under, err_over, ext_req;
  logic [4:0] mute_en, irq_en, clr;
  logic mute_pol;
  logic [CW-1:0] meas_count;
  logic meas_stb;
  logic [4:0] err_flags;
  logic mute_out, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  initial begin
    mclk = 1'b0;
    #7;
    forever #(mclk_half) mclk = ~mclk;
  end

  clkmon_mute i_clkmon_mute (
    .clk_sys(clk), .rst_n(rst_n), .mclk_in(mclk), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .src_proto_err(err_proto), .src_underrun(err_under), .src_overrun(err_over),
    .src_ext_mute(ext_req), .mute_en(mute_en), .irq_en(irq_en), .mute_pol(mute_pol),
    .clr_w1c(clr), .meas_count(meas_count), .meas_stb(meas_stb), .err_flags(err_flags),
    .mute_out(mute_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_meas(input int value, input int windows);
    for (int i = 0; i < windows; i++) exp_q.push_back(value);
  endtask

  // monitor side: compare each published measurement with the queue head
  always @(negedge clk) begin
    if (rst_n && meas_stb && exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      chk(meas_count == CW'(e), "R1 window count", meas_count, e);
    end
  end

  task automatic wait_stb(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!meas_stb) @(negedge clk);
    end
  endtask

  task automatic clear_flags(input logic [4:0] v);
    @(negedge clk) clr = v;
    @(negedge clk) clr = '0;
  endtask

  initial begin
    rst_n = 1'b0; lim_lo = 6'd0; lim_hi = 6'd63;
    err_proto = 0; err_under = 0; err_over = 0; ext_req = 0;
    mute_en = '0; irq_en = '0; clr = '0; mute_pol = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(err_flags == 5'b0, "R8 flags", err_flags, 0);
    chk(meas_count == '0, "R8 count", meas_count, 0);
    chk(meas_stb == 1'b0, "R8 stb", meas_stb, 0);
    chk(irq == 1'b0, "R8 irq", irq, 0);
    chk(mute_out == 1'b0, "R8 mute", mute_out, 0);
    lim_lo = 6'd40; lim_hi = 6'd50;
    @(negedge clk) rst_n = 1'b1;

    // R3: first window out of limits is ignored; R2: second one flags
    wait_stb(1);
    @(negedge clk);
    chk(err_flags[3] == 1'b0, "R3 first window skipped", err_flags[3], 0);
    wait_stb(1);
    @(negedge clk);
    chk(err_flags[3] == 1'b1, "R2 count below limit", err_flags[3], 1);

    // R1 count with 80 ns master clock, in limits
    lim_lo = 6'd6; lim_hi = 6'd10;
    clear_flags(5'b01000);
    chk(err_flags == 5'b0, "R4 clear range flag", err_flags, 0);
    expect_meas(8, 3);
    wait_stb(3);
    @(negedge clk);
    chk(err_flags[3] == 1'b0, "R2 in range no flag", err_flags[3], 0);

    // R1/R2 160 ns period: 4 edges, below lo
    mclk_half = 80;
    wait_stb(2);
    expect_meas(4, 2);
    wait_stb(2);
    @(negedge clk);
    chk(err_flags[3] == 1'b1, "R2 low count flags", err_flags[3], 1);

    // R1/R2 40 ns period: 16 edges, above hi
    mclk_half = 20;
    wait_stb(2);
    clear_flags(5'b01000);
    expect_meas(16, 2);
    wait_stb(2);
    @(negedge clk);
    chk(err_flags[3] == 1'b1, "R2 high count flags", err_flags[3], 1);
    lim_hi = 6'd63;
    wait_stb(1);
    clear_flags(5'b01000);
    chk(exp_q.size() == 0, "R1 all measurements seen", exp_q.size(), 0);

    // R5/R6 source selection and immediate mute
    mute_en = 5'b00001;
    @(negedge clk) err_over = 1'b1;
    #1 chk(mute_out == 1'b0, "R6 unselected overrun", mute_out, 0);
    @(negedge clk) err_over = 1'b0;
    chk(err_flags == 5'b00100, "R4 overrun flag bit2", err_flags, 5'b00100);
    chk(mute_out == 1'b0, "R6 unselected flag", mute_out, 0);
    @(negedge clk) err_proto = 1'b1;
    #1 chk(mute_out == 1'b1, "R5 immediate mute", mute_out, 1);
    @(negedge clk) err_proto = 1'b0;
    @(negedge clk);
    chk(err_flags == 5'b00101, "R4 sticky flags", err_flags, 5'b00101);
    chk(mute_out == 1'b1, "R5 mute held", mute_out, 1);
    mute_pol = 1'b0;
    #1 chk(mute_out == 1'b0, "R5 active-low mute", mute_out, 0);
    mute_pol = 1'b1;
    @(negedge clk) begin err_proto = 1'b1; clr = 5'b00001; end
    @(negedge clk) begin err_proto = 1'b0; clr = '0; end
    chk(err_flags[0] == 1'b1, "R4 set beats clear", err_flags[0], 1);
    clear_flags(5'b00101);
    chk(err_flags == 5'b0, "R4 w1c clears", err_flags, 0);
    chk(mute_out == 1'b0, "R5 mute released", mute_out, 0);

    // R7 interrupt gating
    irq_en = 5'b00010;
    chk(irq == 1'b0, "R7 irq idle", irq, 0);
    @(negedge clk) err_under = 1'b1;
    @(negedge clk) err_under = 1'b0;
    chk(irq == 1'b1, "R7 irq on underrun", irq, 1);
    chk(mute_out == 1'b0, "R6 underrun not muting", mute_out, 0);
    irq_en = 5'b00000;
    #1 chk(irq == 1'b0, "R7 irq masked", irq, 0);
    clear_flags(5'b00010);

    // R5 external mute request
    mute_en = 5'b10000;
    @(negedge clk) ext_req = 1'b1;
    #1 chk(mute_out == 1'b1, "R5 external mute", mute_out, 1);
    @(negedge clk) ext_req = 1'b0;
    chk(err_flags == 5'b10000, "R4 ext flag bit4", err_flags, 5'b10000);
    clear_flags(5'b10000);
    chk(mute_out == 1'b0, "R5 external released", mute_out, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule